// File: doc/BRIEF.md
# Erase-Block Grouping Request Reorderer

This block sits in front of a flash translation layer. It gathers a window of read and write requests, each carrying an erase-block number and a payload. It then emits them again so that the writes aimed at one erase block come out back to back. The translation layer can then place them together in a single log or free block and needs fewer merges and garbage collections.

Flash has no seek penalty, so reads are not moved for speed. A read keeps its place unless an earlier write in the same window targets its block. In that case the read travels with that block's group, so it still follows the write. Requests that share a block never change their relative order.

The window closes when it is full or after a run of idle input cycles. It is then drained completely before new requests are taken in. Both edges are valid/ready streams.

Top module: `blk_group_reorder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The window holds DEPTH (16) requests. After the 16th accepted request, in_ready is 0 until every request of that window has been emitted. After that it returns to 1.
- R3: A partly filled window closes after IDLE_MAX (8) consecutive cycles without an accepted request. No request is emitted before it closes.
- R4: When the scan of the window reaches a write to block B that is not yet emitted, that write is emitted first. It is followed directly by every remaining request (read or write) to block B, in arrival order.
- R5: Write groups leave in the order in which each block's first write arrived in the window.
- R6: A read whose block has no earlier write in the window is emitted at its arrival position relative to the other traffic that is not held back.
- R7: Requests to the same block are emitted in their arrival order.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_wr, out_blk and out_data hold their values.
- R9: Every accepted request is emitted exactly once, with its type, block and payload unchanged. in_wr=1 marks a write and in_wr=0 marks a read.
- R10: The input R70 R10 R50 W70 W10 W50 R70 R10 R50 W70 W10 W50, closed by the idle timeout, leaves as R70 R10 R50 W70 R70 W70 W10 R10 W10 W50 R50 W50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Window can take a request |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_blk | input | BLK_W | Erase-block number of the request |
| in_data | input | DATA_W | Payload carried unchanged |
| out_valid | output | 1 | Output request valid |
| out_ready | input | 1 | Downstream takes the request |
| out_wr | output | 1 | Type of the emitted request |
| out_blk | output | BLK_W | Erase block of the emitted request |
| out_data | output | DATA_W | Payload of the emitted request |

## Verification
The sweep covers every window length from one to sixteen over block alphabets of one, two, four and eight values. Each mix of reads and writes is compared against an ordering computed from the grouping rule.

- A design that let a held-back read escape early would place that read ahead of the write before it.
- A design that sorted groups by block number, instead of by first write, would fail whenever the blocks' first writes arrive out of numeric order.
- Windows exactly full, with sixteen entries, test the close on capacity. An off-by-one there would drop or duplicate the last entry, or merge it into the next window.
- Random backpressure stalls the output in the middle of a group. A design that advanced its selection during a stall would skip or repeat requests.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } rq_state_e;
endpackage

// File: rtl/rq_store.sv
module rq_store #(
  parameter int DEPTH  = 16,
  parameter int BLK_W  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic                        wwr,
  input  logic [BLK_W-1:0]            wblk,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        clr,
  input  logic [IDX_W-1:0]            cidx,
  input  logic                        re,
  input  logic [IDX_W-1:0]            ridx,
  output logic [DEPTH-1:0]            valid,
  output logic [DEPTH-1:0]            wr_vec,
  output logic [DEPTH-1:0][BLK_W-1:0] blk_vec,
  output logic [DATA_W-1:0]           rdata
);
  // Payload kept in a plain memory with a synchronous read port
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end

  // Type and block stay in flops: every entry is compared in parallel
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= '0;
      wr_vec  <= '0;
      blk_vec <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we && widx == IDX_W'(i)) begin
          valid[i]   <= 1'b1;
          wr_vec[i]  <= wwr;
          blk_vec[i] <= wblk;
        end else if (clr && cidx == IDX_W'(i)) begin
          valid[i] <= 1'b0;
        end
      end
    end
  end

  // R9: a live entry is never overwritten and never emitted twice
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst) we |-> !valid[widx]);
  p_clr_live_r9:     assert property (@(posedge clk) disable iff (rst) clr |-> valid[cidx]);
endmodule

// File: rtl/rq_pick.sv
module rq_pick #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH-1:0]            pend,
  input  logic [DEPTH-1:0][BLK_W-1:0] blk_vec,
  input  logic                        grp_act,
  input  logic [BLK_W-1:0]            grp_blk,
  output logic                        any,
  output logic [IDX_W-1:0]            idx,
  output logic                        in_grp
);
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] cand;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = pend[g] && (blk_vec[g] == grp_blk);
  end

  always_comb begin
    in_grp = grp_act && (|match);
    cand   = in_grp ? match : pend;
    any    = |cand;
    idx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end

  // Checker-side view: does an older pending entry share the chosen block?
  logic older_same;
  always_comb begin
    older_same = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (IDX_W'(i) < idx && pend[i] && blk_vec[i] == blk_vec[idx]) older_same = 1'b1;
    end
  end

  p_sel_pending_r9:   assert property (@(posedge clk) disable iff (rst) any |-> pend[idx]);
  p_same_blk_order_r7: assert property (@(posedge clk) disable iff (rst) any |-> !older_same);
endmodule

// File: rtl/rq_idle_timer.sv
module rq_idle_timer #(
  parameter int IDLE_MAX = 8,
  localparam int CNT_W = $clog2(IDLE_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == CNT_W'(IDLE_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (expire)   cnt <= '0;
    else if (run)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/blk_group_reorder.sv
module blk_group_reorder #(
  parameter int DEPTH    = 16,
  parameter int BLK_W    = 8,
  parameter int DATA_W   = 16,
  parameter int IDLE_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wr,
  input  logic [BLK_W-1:0]  in_blk,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr,
  output logic [BLK_W-1:0]  out_blk,
  output logic [DATA_W-1:0] out_data
);
  import rq_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rq_state_e               state;
  logic [CNT_W-1:0]        count;
  logic                    grp_act;
  logic [BLK_W-1:0]        grp_blk;
  logic [DEPTH-1:0]        valid;
  logic [DEPTH-1:0]        wr_vec;
  logic [DEPTH-1:0][BLK_W-1:0] blk_vec;
  logic [DEPTH-1:0]        pend;
  logic                    pick_any;
  logic [IDX_W-1:0]        pick_idx;
  logic                    pick_in_grp;
  logic                    accept;
  logic                    close_full;
  logic                    expire;
  logic                    load;

  assign in_ready   = (state == ST_COLLECT) && (count != CNT_W'(DEPTH));
  assign accept     = in_valid && in_ready;
  assign close_full = accept && (count == CNT_W'(DEPTH - 1));
  assign pend       = (state == ST_DRAIN) ? valid : '0;
  assign load       = (!out_valid || out_ready) && pick_any;

  rq_store #(.DEPTH(DEPTH), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (accept),
    .widx    (count[IDX_W-1:0]),
    .wwr     (in_wr),
    .wblk    (in_blk),
    .wdata   (in_data),
    .clr     (load),
    .cidx    (pick_idx),
    .re      (load),
    .ridx    (pick_idx),
    .valid   (valid),
    .wr_vec  (wr_vec),
    .blk_vec (blk_vec),
    .rdata   (out_data)
  );

  rq_pick #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .blk_vec (blk_vec),
    .grp_act (grp_act),
    .grp_blk (grp_blk),
    .any     (pick_any),
    .idx     (pick_idx),
    .in_grp  (pick_in_grp)
  );

  rq_idle_timer #(.IDLE_MAX(IDLE_MAX)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    ((state == ST_COLLECT) && (count != '0) && !accept),
    .clear  (accept || (state != ST_COLLECT)),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      count     <= '0;
      grp_act   <= 1'b0;
      grp_blk   <= '0;
      out_valid <= 1'b0;
      out_wr    <= 1'b0;
      out_blk   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (accept) count <= count + 1'b1;
          if (close_full || expire) state <= ST_DRAIN;
        end
        default: begin
          if (valid == '0) begin
            state   <= ST_COLLECT;
            count   <= '0;
            grp_act <= 1'b0;
          end
        end
      endcase

      if (load) begin
        out_valid <= 1'b1;
        out_wr    <= wr_vec[pick_idx];
        out_blk   <= blk_vec[pick_idx];
        if (!pick_in_grp) begin
          // A new scan position: a write opens its block's group, a read closes any group
          grp_act <= wr_vec[pick_idx];
          grp_blk <= blk_vec[pick_idx];
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_wr) && $stable(out_blk) && $stable(out_data)));
  p_group_next_r4: assert property (@(posedge clk) disable iff (rst)
    (load && pick_in_grp) |=> (out_blk == $past(grp_blk)));
  p_full_close_r2: assert property (@(posedge clk) disable iff (rst) close_full |=> !in_ready);
  p_idle_close_r3: assert property (@(posedge clk) disable iff (rst) expire |=> (state == ST_DRAIN));
endmodule

// File: tb/blk_group_reorder_tb.sv
module blk_group_reorder_tb;
  localparam int DEPTH = 16;
  localparam int BLK_W = 8;
  localparam int DATA_W = 16;
  localparam int IDLE_MAX = 8;
  localparam int MAXQ = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_wr = 1'b0, out_ready = 1'b1;
  logic [BLK_W-1:0] in_blk = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_wr;
  logic [BLK_W-1:0] out_blk;
  logic [DATA_W-1:0] out_data;

  always #2.5 clk = ~clk;

  blk_group_reorder #(.DEPTH(DEPTH), .BLK_W(BLK_W), .DATA_W(DATA_W), .IDLE_MAX(IDLE_MAX)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_wr(in_wr),
    .in_blk(in_blk), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_wr(out_wr), .out_blk(out_blk), .out_data(out_data));

  int checks = 0, fails = 0;
  int exp_n = 0, got_n = 0, id_ctr = 0;
  logic exp_wr [MAXQ];
  logic [BLK_W-1:0] exp_blk [MAXQ];
  logic [DATA_W-1:0] exp_dat [MAXQ];
  logic got_wr [MAXQ];
  logic [BLK_W-1:0] got_blk [MAXQ];
  logic [DATA_W-1:0] got_dat [MAXQ];
  logic w_wr [DEPTH];
  logic [BLK_W-1:0] w_blk [DEPTH];
  logic bp_on = 1'b0;
  logic [15:0] rl = 16'h1d2b;
  logic [15:0] sl = 16'h7a31;
  logic stalled = 1'b0, h_wr;
  logic [BLK_W-1:0] h_blk;
  logic [DATA_W-1:0] h_dat;
  logic finished = 1'b0;

  function automatic logic [15:0] nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Output side: set ready for the coming edge, then log the handshake of that edge
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        chk(out_valid && out_wr == h_wr && out_blk == h_blk && out_data == h_dat,
            "R8 hold under stall", int'(out_data), int'(h_dat));
      end
      rl = nx(rl);
      out_ready = bp_on ? (rl[0] | rl[3]) : 1'b1;
      if (out_valid && out_ready && got_n < MAXQ) begin
        got_wr[got_n] = out_wr;
        got_blk[got_n] = out_blk;
        got_dat[got_n] = out_data;
        got_n++;
      end
      stalled = out_valid && !out_ready;
      h_wr = out_wr; h_blk = out_blk; h_dat = out_data;
    end
  end

  // Grouping rule from the requirements: reads keep place unless a write to
  // their block came first; a write pulls all later same-block requests.
  task automatic model(input int n, input int base);
    logic done [DEPTH];
    for (int i = 0; i < DEPTH; i++) done[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!done[i]) begin
        if (!w_wr[i]) begin
          exp_wr[exp_n] = 1'b0; exp_blk[exp_n] = w_blk[i]; exp_dat[exp_n] = DATA_W'(base + i);
          exp_n++; done[i] = 1'b1;
        end else begin
          for (int j = i; j < n; j++) begin
            if (!done[j] && w_blk[j] == w_blk[i]) begin
              exp_wr[exp_n] = w_wr[j]; exp_blk[exp_n] = w_blk[j]; exp_dat[exp_n] = DATA_W'(base + j);
              exp_n++; done[j] = 1'b1;
            end
          end
        end
      end
    end
  endtask

  task automatic run_window(input int n, input logic idle_chk);
    int start, base, guard;
    start = exp_n;
    base = id_ctr;
    id_ctr += n;
    model(n, base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_wr = w_wr[k]; in_blk = w_blk[k]; in_data = DATA_W'(base + k);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (n == DEPTH) chk(!in_ready, "R2 ready low when full", int'(in_ready), 0);
    if (idle_chk) begin
      repeat (5) @(negedge clk);
      chk(!out_valid && in_ready && got_n == start, "R3 no emission before timeout", got_n - start, 0);
      repeat (5) @(negedge clk);
      chk(got_n > start, "R3 window closed after idle run", got_n - start, 1);
    end
    guard = 0;
    while (got_n < exp_n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(got_n == exp_n, "R9 emitted count", got_n, exp_n);
    for (int i = start; i < exp_n; i++) begin
      chk(got_wr[i] == exp_wr[i] && got_blk[i] == exp_blk[i] && got_dat[i] == exp_dat[i],
          "R4/R5/R6/R7/R9 order and content", int'(got_dat[i]), int'(exp_dat[i]));
    end
    guard = 0;
    while (!in_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (n == DEPTH) chk(in_ready, "R2 ready back after drain", int'(in_ready), 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [BLK_W-1:0] ex_blk [12];
    logic ex_wr [12];
    int start;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

    // R10: worked example
    for (int i = 0; i < 12; i++) begin
      w_wr[i] = (i % 6) >= 3;
      w_blk[i] = (i % 3 == 0) ? 8'd70 : (i % 3 == 1) ? 8'd10 : 8'd50;
    end
    ex_blk = '{8'd70, 8'd10, 8'd50, 8'd70, 8'd70, 8'd70, 8'd10, 8'd10, 8'd10, 8'd50, 8'd50, 8'd50};
    ex_wr  = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    start = exp_n;
    run_window(12, 1'b0);
    for (int i = 0; i < 12; i++) begin
      chk(got_blk[start + i] == ex_blk[i] && got_wr[start + i] == ex_wr[i],
          "R10 example order", int'(got_blk[start + i]), int'(ex_blk[i]));
    end

    // R3: short window closed only by the idle timeout
    w_wr[0] = 1'b1; w_blk[0] = 8'd3;
    w_wr[1] = 1'b0; w_blk[1] = 8'd5;
    w_wr[2] = 1'b0; w_blk[2] = 8'd3;
    run_window(3, 1'b1);

    // Sweep: every window length over four block alphabets, with and without backpressure
    for (int pat = 0; pat < 4; pat++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        for (int k = 0; k < n; k++) begin
          sl = nx(sl); sl = nx(sl);
          w_wr[k] = sl[1];
          w_blk[k] = 8'd20 + BLK_W'(sl[7:4] & 4'((1 << pat) - 1));
        end
        bp_on = pat[0];
        run_window(n, 1'b0);
      end
    end
    bp_on = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule